// File: doc/BRIEF.md
# Synchronous Flow-Through Byte-Write SRAM

This block is the front end of a single-clock static RAM with a small behavioural storage array. A word is four 9-bit lanes. The address, the write data and every control input are captured on the rising clock edge. The access they describe is carried out in the cycle that follows that edge.

A read has no output register. The stored word reaches the output combinationally during the cycle after the sampling edge. A write is captured at one edge and stored at the next edge. A write can update a chosen set of lanes, or it can update the whole word at once through a global write input.

An access begins with an address strobe. On that edge three chip-select inputs are sampled, and all three must be active for the device to be selected. The selection state is then held across the beats of a 2-bit burst. The burst visits the four words of an aligned group in linear order or in interleaved order. A strobe whose chip selects are not all active deselects the part, and the bus stops being driven in the very next cycle.

The shared data bus is modelled as separate input and output ports plus a drive flag. When the bus is not driven, the output port reads as zero.

Top module: `sram_ft_core`

## Requirements
- R1: After reset, `dout_en` is 0 and `dout` is 0 until a selecting strobe is sampled.
- R2: An edge with `load_n`=0 selects the device only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0 all hold. While the device is deselected, writes leave the array unchanged and `bus` is not driven.
- R3: In the cycle after an edge where `load_n`=0 and any chip select is inactive, `dout_en` is 0 and `dout` is 0.
- R4: In a read cycle the device is selected and no lane is write-enabled. During the cycle right after the sampling edge, `dout` equals the stored word at the current burst address and `dout_en` is 1.
- R5: When `wr_all_n`=1 and `wr_byte_n`=0, each lane i with `lane_n[i]`=0 takes `din[9i+8:9i]`, and the other lanes keep their contents. A read on the next cycle returns the updated word.
- R6: When `wr_all_n`=0, all four lanes are written, whatever the values of `wr_byte_n` and `lane_n`.
- R7: A cycle in which no lane is write-enabled is a read. This covers `wr_all_n`=1 with `wr_byte_n`=1, and also `wr_byte_n`=0 with `lane_n`=4'b1111.
- R8: With `interleave`=0 sampled at the strobe, beat k uses address bits [1:0] equal to (a+k) mod 4, where a is bits [1:0] of the strobed address. The upper address bits stay unchanged. The beat count k is reset to 0 at the strobe and advances by one on each edge with `load_n`=1 and `adv_n`=0. It holds otherwise.
- R9: With `interleave`=1 sampled at the strobe, beat k uses address bits [1:0] equal to a XOR k.
- R10: On edges with `load_n`=1, the chip selects are ignored and the selection state of the last strobe persists.
- R11: During a write cycle, `dout_en` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, captured when `load_n` is low |
| load_n | input | 1 | Address strobe, active low: starts a burst and samples the chip selects |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order captured at the strobe: 0 linear, 1 interleaved |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low: writes all lanes |
| wr_byte_n | input | 1 | Lane-write enable, active low: qualifies `lane_n` |
| lane_n | input | LANES | Per-lane write selects, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data; 0 when the bus is not driven |
| dout_en | output | 1 | Bus drive flag; 0 models high impedance |

## Verification
The hardest situation to reach from the ports is a write attempted while a deselected state persists through a burst: the write is ignored, and the lost write can only be seen after a later reselect and a read of the same word. The stimulus therefore deselects with a strobe, attempts non-strobe writes while asserting valid chip selects, and then reselects and reads back. The wrap of a burst across an aligned group is reached in both orders by directed strobes at unaligned addresses. A long random phase then mixes strobes, advances, lane masks and global writes over a fully initialised array.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;

  // low address bits of a burst beat: linear adds, interleaved toggles
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          ilv_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] ea
);
  import sram_pkg::*;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          ilv_q, ilv_d;
  logic          cnt_en;

  assign cnt_en = load | adv;

  always_comb begin
    base_d = base_q;
    ilv_d  = ilv_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = addr_in;
      ilv_d  = ilv_in;
      cnt_d  = 2'd0;
    end else if (adv) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      if (load) begin
        base_q <= base_d;
        ilv_q  <= ilv_d;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ea = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_q, ilv_q)};

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0) && (base_q == $past(addr_in))); // R8
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ea)); // R8
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    sel_ok,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    sel_q,
  output logic [LANES-1:0]        wmask_q,
  output logic [LANES*LANE_W-1:0] wdata_q
);
  localparam int unsigned DW = LANES * LANE_W;

  logic             sel_d;
  logic [LANES-1:0] wmask_d;

  always_comb begin
    sel_d = load ? sel_ok : sel_q;
    if (!wr_all_n)       wmask_d = '1;
    else if (!wr_byte_n) wmask_d = ~lane_n;
    else                 wmask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wmask_q <= '0;
      wdata_q <= {DW{1'b0}};
    end else begin
      if (load) sel_q <= sel_d;
      wmask_q <= wmask_d;
      wdata_q <= din;
    end
  end

  AST_SEL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q)); // R10
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_all_n |=> (wmask_q == {LANES{1'b1}})); // R6
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem_l[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem_l[addr];

    AST_LANE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> (mem_l[$past(addr)] == $past(wdata[g*LANE_W +: LANE_W]))); // R5
  end
endmodule

// File: rtl/sram_ft_core.sv
module sram_ft_core #(
  parameter int unsigned AW = 6
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [AW-1:0]                               addr,
  input  logic                                        load_n,
  input  logic                                        adv_n,
  input  logic                                        interleave,
  input  logic                                        sel0_n,
  input  logic                                        sel1,
  input  logic                                        sel2_n,
  input  logic                                        wr_all_n,
  input  logic                                        wr_byte_n,
  input  logic [sram_pkg::LANES-1:0]                  lane_n,
  input  logic [sram_pkg::WORD_W-1:0]                 din,
  output logic [sram_pkg::WORD_W-1:0]                 dout,
  output logic                                        dout_en
);
  import sram_pkg::*;

  logic              load, sel_ok;
  logic              sel_q;
  logic [LANES-1:0]  wmask_q, we;
  logic [WORD_W-1:0] wdata_q, rdata;
  logic [AW-1:0]     ea;

  assign load   = ~load_n;
  assign sel_ok = ~sel0_n & sel1 & ~sel2_n;

  sram_burst_seq #(.AW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (~adv_n),
    .ilv_in  (interleave),
    .addr_in (addr),
    .ea      (ea)
  );

  sram_access_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .sel_ok    (sel_ok),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_n    (lane_n),
    .din       (din),
    .sel_q     (sel_q),
    .wmask_q   (wmask_q),
    .wdata_q   (wdata_q)
  );

  assign we = sel_q ? wmask_q : '0;

  sram_byte_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .addr  (ea),
    .wdata (wdata_q),
    .rdata (rdata)
  );

  assign dout_en = sel_q & (wmask_q == '0);
  assign dout    = dout_en ? rdata : '0;

  AST_DESEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && (sel0_n || !sel1 || sel2_n)) |=> (!dout_en && dout == '0)); // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_all_n |=> !dout_en); // R11
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (we == '0)); // R2
endmodule

// File: tb/tb_sram_ft_core.sv
module tb_sram_ft_core;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int W = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic load_n, adv_n, interleave, sel0_n, sel1, sel2_n;
  logic wr_all_n, wr_byte_n;
  logic [3:0] lane_n;
  logic [W-1:0] din, dout;
  logic dout_en;

  always #4 clk = ~clk;

  sram_ft_core #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load_n(load_n), .adv_n(adv_n),
    .interleave(interleave), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  int n_vec = 0, n_bad = 0;
  logic [W-1:0] model [DEPTH];
  logic m_sel;
  logic [AW-1:0] m_base;
  logic [1:0] m_cnt;
  logic m_ilv;

  function automatic logic [3:0] exp_mask(logic all_n, logic byte_n, logic [3:0] ln);
    if (!all_n) return 4'hF;
    if (!byte_n) return ~ln;
    return 4'h0;
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ k) : ((b[1:0] + k) & 2'b11);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    load_n = 1; adv_n = 1; interleave = 0; sel0_n = 0; sel1 = 1; sel2_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; din = '0; addr = '0;
  endtask

  // apply current inputs for one edge, update the model, check outputs
  task automatic step(string tag);
    logic [3:0] mk;
    logic [AW-1:0] ea;
    logic en;
    logic [W-1:0] d;
    if (!load_n) begin
      m_sel = !sel0_n && sel1 && !sel2_n;
      m_base = addr; m_cnt = 0; m_ilv = interleave;
    end else if (!adv_n) m_cnt = m_cnt + 2'd1;
    mk = exp_mask(wr_all_n, wr_byte_n, lane_n);
    d = din;
    @(posedge clk); #2;
    ea = exp_addr(m_base, m_cnt, m_ilv);
    en = m_sel && (mk == 4'h0);
    chk({tag, " dout_en"}, {35'd0, dout_en}, {35'd0, en});
    chk({tag, " dout"}, dout, en ? model[ea] : '0);
    if (m_sel)
      for (int i = 0; i < 4; i++)
        if (mk[i]) model[ea][9*i +: 9] = d[9*i +: 9];
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    idle();
    rst_n = 0;
    m_sel = 0; m_base = '0; m_cnt = 0; m_ilv = 0;
    repeat (3) @(negedge clk);
    chk("R1 dout_en at reset", {35'd0, dout_en}, 36'd0);
    chk("R1 dout at reset", dout, 36'd0);
    rst_n = 1;
    @(negedge clk);
    step("R1 idle after reset");

    // fill: global write overrides lane selects
    for (int i = 0; i < DEPTH; i++) begin
      idle(); load_n = 0; addr = i[AW-1:0]; wr_all_n = 0;
      wr_byte_n = i[0]; lane_n = i[3:0];
      din = {i[8:0] ^ 9'h1A5, i[8:0] ^ 9'h0F3, i[8:0], 9'h100 | i[8:0]};
      step("R6 R11 global write");
    end
    for (int i = 0; i < 4; i++) begin
      idle(); load_n = 0; addr = 6'(8 + i);
      step("R6 readback");
    end

    // linear burst wrap from a=1
    idle(); load_n = 0; addr = 6'd13; step("R4 R8 linear beat0");
    for (int k = 1; k < 5; k++) begin
      idle(); adv_n = 0; step("R8 linear advance");
    end
    idle(); step("R8 hold without advance");
    // interleaved burst from a=2
    idle(); load_n = 0; addr = 6'd22; interleave = 1; step("R9 interleave beat0");
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; step("R9 interleave advance");
    end

    // lane write and readback
    idle(); load_n = 0; addr = 6'd30; wr_byte_n = 0; lane_n = 4'b1010;
    din = 36'hA_BCDE_F012; step("R5 lane write");
    idle(); step("R5 readback");
    idle(); wr_byte_n = 0; lane_n = 4'hF; din = 36'hF_FFFF_FFFF;
    step("R7 empty lane mask is a read");
    idle(); wr_byte_n = 1; wr_all_n = 1; step("R7 plain read");

    // deselect, persist, ignored write
    idle(); load_n = 0; addr = 6'd40; sel1 = 0; step("R3 deselect one cycle");
    idle(); wr_all_n = 0; din = 36'h0_1234_5678; step("R2 R10 write ignored while deselected");
    idle(); adv_n = 0; step("R10 still deselected");
    idle(); load_n = 0; addr = 6'd40; sel2_n = 1; step("R2 sel2 inactive");
    idle(); load_n = 0; addr = 6'd40; sel0_n = 1; step("R2 sel0 inactive");
    idle(); load_n = 0; addr = 6'd40; step("R2 reselect read unchanged");
    idle(); sel0_n = 1; sel1 = 0; sel2_n = 1; step("R10 selection persists");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      load_n = ($urandom % 4) != 0;
      adv_n = $urandom % 2;
      interleave = $urandom % 2;
      addr = 6'($urandom);
      if (($urandom % 4) == 0) begin
        sel0_n = $urandom % 2; sel1 = $urandom % 2; sel2_n = $urandom % 2;
      end
      case ($urandom % 4)
        0: wr_all_n = 0;
        1: begin wr_byte_n = 0; lane_n = 4'($urandom); end
        default: ;
      endcase
      wr_byte_n = wr_byte_n & ($urandom % 8 != 0 ? wr_byte_n : 1'b0);
      din = {4'($urandom), 32'($urandom)};
      step("R4 R5 R6 R8 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule